// File: doc/BRIEF.md
# Block-Chaining DMA Request Sequencer

This block paces a multi-channel DMA controller around a 128-bit block cipher engine so that a long message can be processed in ECB, CBC, OFB or CFB without software touching each block. Software sets a chaining mode and a direction, raises the enable, and writes a non-zero block count. From then on the block drives three level-sensitive request lines, one at a time. Each line is bound to a DMA channel that moves 16 bytes through one of four engine data ports: the output read, the plain input write, the XOR input write, and the XOR input write that also launches the cipher.

The sequencer counts the byte or word strobes that arrive on the port it is currently watching. It drops a request the cycle after the 16th byte has moved and raises the next request in the chain for the selected mode. It also pulses a cipher start toward the engine and counts finished blocks. When the last block's output has been read out, it returns to idle. In the chained modes the first block is written by software without a request. In ECB the first block is requested like the others.

Top module: `cmdma_trig_seq`

## Requirements
- R1: While the enable is low, a block-count write is ignored and all requests stay low. Dropping the enable while busy returns the block to idle, with requests and busy low from the next cycle.
- R2: After reset, busy, start and all requests are low. A count write of a non-zero value with the enable high sets busy from the next cycle. A count write of zero leaves the block idle.
- R3: Every request group moves exactly 16 bytes: 8 strobes when the access-width input is 1 (word) or 16 strobes when it is 0 (byte). The request stays high until the completing strobe and is low in the cycle after it.
- R4: Mode 00 (ECB), either direction: request 1 loads the first block into the plain input port. After each cipher completion, request 0 reads the output port, then request 1 loads the next block. Request 2 never rises.
- R5: Mode 01 (CBC) with direction 00 (encrypt): the first block enters via the XOR-with-start port with no request. After completion, request 0 reads the output and request 1 writes the XOR-with-start port.
- R6: Mode 01 with direction 01 or 11 (decrypt): the first block enters via the plain input port with no request. After completion, request 0 writes the XOR input port, request 1 reads the output, and request 2 writes the plain input port.
- R7: Mode 10 (OFB), either direction: the first block enters via the XOR-with-start port. After completion, request 0 writes the XOR input, request 1 reads the output, and request 2 writes the XOR-with-start port.
- R8: Mode 11 (CFB): the first block enters via the plain input port. After completion, request 0 writes the XOR input and request 1 reads the output. For decrypt, request 2 then writes the plain input port. For encrypt, the completed output read itself launches the next block.
- R9: At most one request is high at a time. A request later in a chain rises only after the previous request's group has completed.
- R10: Start is a one-cycle pulse in the cycle after the 16th byte reaches the launching port of the current step, or after the output read that ends a CFB encrypt chain. A count of N yields exactly N start pulses.
- R11: Each cipher completion lowers the remaining count by one. Once the last block's output read completes, the remaining steps of that block are skipped, and requests and busy are low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cm_en_i | input | 1 | Enables DMA request generation |
| mode_i | input | 2 | Chaining mode: 00 ECB, 01 CBC, 10 OFB, 11 CFB |
| op_i | input | 2 | Direction: 00 encrypt, 01/11 decrypt |
| blk_wr_i | input | 1 | Block-count write strobe |
| blk_cnt_i | input | CNT_W | Block count value |
| cipher_done_i | input | 1 | One-cycle completion pulse from the engine |
| acc_word_i | input | 1 | Width of the current strobe: 1 word, 0 byte |
| dout_rd_i | input | 1 | Output port read strobe |
| din_wr_i | input | 1 | Plain input port write strobe |
| xin_wr_i | input | 1 | XOR input write strobe (no launch) |
| xstart_wr_i | input | 1 | XOR input write strobe that launches |
| trig_o | output | 3 | Level-sensitive DMA requests 0..2 |
| start_o | output | 1 | One-cycle cipher start pulse |
| busy_o | output | 1 | Sequence in progress |

## Verification
The assertions assume that the engine raises its completion pulse only after a start, and that a DMA channel strobes only the port bound to the request it serves, one strobe per cycle, with no further strobes once the request is low. They also assume that mode and direction are stable while the count is written. The bench keeps within these limits with a DMA model that serves only a high request and maps each request index to its port from its own table for the selected mode. Its engine model answers each start with one completion a fixed number of cycles later. The first, unrequested block is written through the same model only while no request is high.

// File: rtl/cmdma_pkg.sv
package cmdma_pkg;

  localparam int NUM_TRIG      = 3;
  localparam int ECB_LOAD_TRIG = 1;

  typedef enum logic [1:0] {
    CM_ECB = 2'b00,
    CM_CBC = 2'b01,
    CM_OFB = 2'b10,
    CM_CFB = 2'b11
  } cmode_e;

  typedef enum logic [2:0] {
    PT_NONE,
    PT_DOUT_RD,
    PT_DIN_WR,
    PT_XIN_WR,
    PT_XSTART_WR
  } port_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LOAD,
    SQ_RUN,
    SQ_CHAIN
  } sq_state_e;

  typedef struct packed {
    port_e port;
    logic  last;
  } step_t;

endpackage

// File: rtl/cmdma_chain_map.sv
module cmdma_chain_map
  import cmdma_pkg::*;
(
  input  cmode_e     mode_i,
  input  logic       dec_i,
  input  logic [1:0] step_i,
  output step_t      step_o,
  output port_e      load_port_o
);

  // First-block entry port for each mode/direction
  always_comb begin
    load_port_o = PT_DIN_WR;
    case (mode_i)
      CM_ECB: load_port_o = PT_DIN_WR;
      CM_CBC: load_port_o = dec_i ? PT_DIN_WR : PT_XSTART_WR;
      CM_OFB: load_port_o = PT_XSTART_WR;
      CM_CFB: load_port_o = PT_DIN_WR;
      default: load_port_o = PT_DIN_WR;
    endcase
  end

  // Chain step table: request index equals step index
  always_comb begin
    step_o = '{port: PT_NONE, last: 1'b1};
    case (mode_i)
      CM_ECB: begin
        case (step_i)
          2'd0:    step_o = '{port: PT_DOUT_RD, last: 1'b0};
          2'd1:    step_o = '{port: PT_DIN_WR,  last: 1'b1};
          default: step_o = '{port: PT_NONE,    last: 1'b1};
        endcase
      end
      CM_CBC: begin
        if (dec_i) begin
          case (step_i)
            2'd0:    step_o = '{port: PT_XIN_WR,  last: 1'b0};
            2'd1:    step_o = '{port: PT_DOUT_RD, last: 1'b0};
            2'd2:    step_o = '{port: PT_DIN_WR,  last: 1'b1};
            default: step_o = '{port: PT_NONE,    last: 1'b1};
          endcase
        end else begin
          case (step_i)
            2'd0:    step_o = '{port: PT_DOUT_RD,   last: 1'b0};
            2'd1:    step_o = '{port: PT_XSTART_WR, last: 1'b1};
            default: step_o = '{port: PT_NONE,      last: 1'b1};
          endcase
        end
      end
      CM_OFB: begin
        case (step_i)
          2'd0:    step_o = '{port: PT_XIN_WR,    last: 1'b0};
          2'd1:    step_o = '{port: PT_DOUT_RD,   last: 1'b0};
          2'd2:    step_o = '{port: PT_XSTART_WR, last: 1'b1};
          default: step_o = '{port: PT_NONE,      last: 1'b1};
        endcase
      end
      CM_CFB: begin
        case (step_i)
          2'd0:    step_o = '{port: PT_XIN_WR,  last: 1'b0};
          2'd1:    step_o = '{port: PT_DOUT_RD, last: !dec_i};
          2'd2:    step_o = dec_i ? '{port: PT_DIN_WR, last: 1'b1}
                                  : '{port: PT_NONE,   last: 1'b1};
          default: step_o = '{port: PT_NONE,    last: 1'b1};
        endcase
      end
      default: step_o = '{port: PT_NONE, last: 1'b1};
    endcase
  end

endmodule

// File: rtl/cmdma_beat_ctr.sv
module cmdma_beat_ctr #(
  parameter int BLK_BYTES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic hit_i,
  input  logic word_i,
  output logic grp_done_o
);

  localparam int CW = $clog2(BLK_BYTES + 1);

  logic [CW-1:0] cnt_q;
  logic [CW:0]   sum;

  assign sum        = {1'b0, cnt_q} + (word_i ? (CW+1)'(2) : (CW+1)'(1));
  assign grp_done_o = hit_i && (sum >= (CW+1)'(BLK_BYTES));

  always_ff @(posedge clk) begin
    if (rst || clr_i || grp_done_o) cnt_q <= '0;
    else if (hit_i)                 cnt_q <= sum[CW-1:0];
  end

  // R3: partial byte count never reaches a full block
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(BLK_BYTES));

endmodule

// File: rtl/cmdma_seq_fsm.sv
module cmdma_seq_fsm
  import cmdma_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       op_i,
  input  logic             done_i,
  input  logic             grp_done_i,
  input  step_t            step_i,
  input  port_e            load_port_i,
  output cmode_e           mode_o,
  output logic             dec_o,
  output logic [1:0]       step_o,
  output port_e            watch_o,
  output logic             clr_o,
  output logic [NUM_TRIG-1:0] trig_o,
  output logic             start_o,
  output logic             busy_o
);

  sq_state_e        st_q, nxt;
  logic [1:0]       step_q, nstep;
  logic [CNT_W-1:0] blk_q, nblk;
  cmode_e           mode_q, mode_n;
  logic             dec_q;
  logic             start_n;
  logic [NUM_TRIG-1:0] trig_q;
  logic             start_q, busy_q;

  assign mode_n = (st_q == SQ_IDLE) ? cmode_e'(mode_i) : mode_q;

  always_comb begin
    nxt     = st_q;
    nstep   = step_q;
    nblk    = blk_q;
    start_n = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (en_i && cnt_wr_i && (cnt_val_i != '0)) begin
          nxt  = SQ_LOAD;
          nblk = cnt_val_i;
        end
      end
      SQ_LOAD: begin
        if (grp_done_i) begin
          start_n = 1'b1;
          nxt     = SQ_RUN;
        end
      end
      SQ_RUN: begin
        if (done_i) begin
          nblk  = blk_q - CNT_W'(1);
          nstep = 2'd0;
          nxt   = SQ_CHAIN;
        end
      end
      SQ_CHAIN: begin
        if (grp_done_i) begin
          if ((step_i.port == PT_DOUT_RD) && (blk_q == '0)) begin
            nxt = SQ_IDLE;
          end else if (step_i.last) begin
            start_n = 1'b1;
            nxt     = SQ_RUN;
          end else begin
            nstep = step_q + 2'd1;
          end
        end
      end
      default: nxt = SQ_IDLE;
    endcase
    if (!en_i) begin
      nxt     = SQ_IDLE;
      start_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SQ_IDLE;
      step_q  <= 2'd0;
      blk_q   <= '0;
      mode_q  <= CM_ECB;
      dec_q   <= 1'b0;
      start_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      st_q    <= nxt;
      step_q  <= nstep;
      blk_q   <= nblk;
      start_q <= start_n;
      busy_q  <= (nxt != SQ_IDLE);
      if (st_q == SQ_IDLE) begin
        mode_q <= cmode_e'(mode_i);
        dec_q  <= op_i[0];
      end
    end
  end

  // One registered request line per index
  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
    always_ff @(posedge clk) begin
      if (rst) trig_q[g] <= 1'b0;
      else     trig_q[g] <= ((nxt == SQ_LOAD) && (mode_n == CM_ECB) && (g == ECB_LOAD_TRIG))
                         || ((nxt == SQ_CHAIN) && (nstep == 2'(g)));
    end
  end

  always_comb begin
    case (st_q)
      SQ_LOAD:  watch_o = load_port_i;
      SQ_CHAIN: watch_o = step_i.port;
      default:  watch_o = PT_NONE;
    endcase
  end

  assign clr_o   = !en_i || (st_q == SQ_IDLE);
  assign mode_o  = mode_q;
  assign dec_o   = dec_q;
  assign step_o  = step_q;
  assign trig_o  = trig_q;
  assign start_o = start_q;
  assign busy_o  = busy_q;

  // R1: disabled means no request in the following cycle
  a_r1_off_no_trig: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (trig_o == '0));

  // R2: zero count written while idle does not start a sequence
  a_r2_zero_ignored: assert property (@(posedge clk) disable iff (rst)
    ((st_q == SQ_IDLE) && cnt_wr_i && (cnt_val_i == '0)) |=> !busy_o);

  // R9: requests are mutually exclusive
  a_r9_one_trig: assert property (@(posedge clk) disable iff (rst)
    $onehot0(trig_o));

  // R4: ECB never uses the third request
  a_r4_ecb_no_t2: assert property (@(posedge clk) disable iff (rst)
    (busy_o && (mode_q == CM_ECB)) |-> !trig_o[2]);

  // R10: start is a single-cycle pulse
  a_r10_start_single: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  // R11: each completion while waiting lowers the remaining count
  a_r11_blk_dec: assert property (@(posedge clk) disable iff (rst)
    ((st_q == SQ_RUN) && done_i && en_i) |=> (blk_q == $past(blk_q) - CNT_W'(1)));

endmodule

// File: rtl/cmdma_trig_seq.sv
module cmdma_trig_seq
  import cmdma_pkg::*;
#(
  parameter int BLOCK_BITS = 128,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cm_en_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       op_i,
  input  logic             blk_wr_i,
  input  logic [CNT_W-1:0] blk_cnt_i,
  input  logic             cipher_done_i,
  input  logic             acc_word_i,
  input  logic             dout_rd_i,
  input  logic             din_wr_i,
  input  logic             xin_wr_i,
  input  logic             xstart_wr_i,
  output logic [2:0]       trig_o,
  output logic             start_o,
  output logic             busy_o
);

  localparam int BLK_BYTES = BLOCK_BITS / 8;

  cmode_e     mode_q;
  logic       dec_q;
  logic [1:0] step_q;
  step_t      step;
  port_e      load_port;
  port_e      watch;
  logic       clr;
  logic       hit;
  logic       grp_done;
  logic [NUM_TRIG-1:0] trig;

  always_comb begin
    case (watch)
      PT_DOUT_RD:   hit = dout_rd_i;
      PT_DIN_WR:    hit = din_wr_i;
      PT_XIN_WR:    hit = xin_wr_i;
      PT_XSTART_WR: hit = xstart_wr_i;
      default:      hit = 1'b0;
    endcase
  end

  cmdma_chain_map map_i (
    .mode_i      (mode_q),
    .dec_i       (dec_q),
    .step_i      (step_q),
    .step_o      (step),
    .load_port_o (load_port)
  );

  cmdma_beat_ctr #(.BLK_BYTES(BLK_BYTES)) ctr_i (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (clr),
    .hit_i      (hit),
    .word_i     (acc_word_i),
    .grp_done_o (grp_done)
  );

  cmdma_seq_fsm #(.CNT_W(CNT_W)) fsm_i (
    .clk         (clk),
    .rst         (rst),
    .en_i        (cm_en_i),
    .cnt_wr_i    (blk_wr_i),
    .cnt_val_i   (blk_cnt_i),
    .mode_i      (mode_i),
    .op_i        (op_i),
    .done_i      (cipher_done_i),
    .grp_done_i  (grp_done),
    .step_i      (step),
    .load_port_i (load_port),
    .mode_o      (mode_q),
    .dec_o       (dec_q),
    .step_o      (step_q),
    .watch_o     (watch),
    .clr_o       (clr),
    .trig_o      (trig),
    .start_o     (start_o),
    .busy_o      (busy_o)
  );

  assign trig_o = trig;

endmodule

// File: tb/cmdma_trig_seq_tb_top.sv
module cmdma_trig_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cm_en_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [1:0] op_i = 2'b00;
  logic       blk_wr_i = 1'b0;
  logic [7:0] blk_cnt_i = 8'd0;
  logic       cipher_done_i = 1'b0;
  logic       acc_word_i = 1'b1;
  logic       dout_rd_i = 1'b0, din_wr_i = 1'b0, xin_wr_i = 1'b0, xstart_wr_i = 1'b0;
  logic [2:0] trig_o;
  logic       start_o, busy_o;

  always #4 clk = ~clk;

  cmdma_trig_seq dut_i (
    .clk(clk), .rst(rst), .cm_en_i(cm_en_i), .mode_i(mode_i), .op_i(op_i),
    .blk_wr_i(blk_wr_i), .blk_cnt_i(blk_cnt_i), .cipher_done_i(cipher_done_i),
    .acc_word_i(acc_word_i), .dout_rd_i(dout_rd_i), .din_wr_i(din_wr_i),
    .xin_wr_i(xin_wr_i), .xstart_wr_i(xstart_wr_i),
    .trig_o(trig_o), .start_o(start_o), .busy_o(busy_o)
  );

  int n_chk = 0, n_bad = 0;
  int mon_chk = 0, mon_bad = 0;
  int wd_bad = 0;
  int starts_seen = 0;
  int sw_req_total = 0, sw_done_total = 0;
  int cfg_mode = 0, cfg_dec = 0;
  logic mon_ignore = 1'b0;
  string cur_tag = "R4";
  int exp_q[$];

  // Port codes: 0 output read, 1 plain input, 2 XOR input, 3 XOR with start
  function automatic int port_for(int m, int d, int k);
    case (m)
      0: return (k == 0) ? 0 : 1;
      1: if (d != 0) return (k == 0) ? 2 : (k == 1) ? 0 : 1;
         else        return (k == 0) ? 0 : 3;
      2: return (k == 0) ? 2 : (k == 1) ? 0 : 3;
      default: return (k == 0) ? 2 : (k == 1) ? 0 : 1;
    endcase
  endfunction

  function automatic int chain_len(int m, int d);
    if (m == 0) return 2;
    if (m == 1) return (d != 0) ? 3 : 2;
    if (m == 2) return 3;
    return (d != 0) ? 3 : 2;
  endfunction

  function automatic int load_port(int m, int d);
    if (m == 1) return (d != 0) ? 1 : 3;
    if (m == 2) return 3;
    return 1;
  endfunction

  function automatic int trig_idx(logic [2:0] t);
    case (t)
      3'b000: return -1;
      3'b001: return 0;
      3'b010: return 1;
      3'b100: return 2;
      default: return -2;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // DMA model: serves the high request on its mapped port, else software load
  always @(negedge clk) begin
    int k;
    int p;
    k = trig_idx(trig_o);
    p = -1;
    if (k >= 0)                               p = port_for(cfg_mode, cfg_dec, k);
    else if (sw_done_total < sw_req_total) begin
      p = load_port(cfg_mode, cfg_dec);
      sw_done_total++;
    end
    dout_rd_i   <= (p == 0);
    din_wr_i    <= (p == 1);
    xin_wr_i    <= (p == 2);
    xstart_wr_i <= (p == 3);
  end

  // Engine model: completion a fixed latency after each start
  int eng_cd = 0;
  always @(negedge clk) begin
    cipher_done_i <= 1'b0;
    if (start_o) eng_cd = 6;
    else if (eng_cd > 0) begin
      eng_cd--;
      if (eng_cd == 0) cipher_done_i <= 1'b1;
    end
  end

  // Monitor: pops expected request order and checks group lengths
  int prev_idx = -1, beats = 0;
  always @(negedge clk) begin
    int idx;
    int e;
    int exp_beats;
    exp_beats = acc_word_i ? 8 : 16;
    if (rst || mon_ignore) begin
      prev_idx = -1;
      beats = 0;
    end else begin
      idx = trig_idx(trig_o);
      if (start_o) starts_seen++;
      if (idx == -2) begin
        mon_chk++; mon_bad++;
        $display("FAIL R9: actual %0d expected one-hot", trig_o);
      end
      if (idx != prev_idx) begin
        if (prev_idx >= 0) begin
          mon_chk++;
          if (beats != exp_beats) begin
            mon_bad++;
            $display("FAIL R3: actual %0d expected %0d beats", beats, exp_beats);
          end
        end
        if (idx >= 0) begin
          mon_chk++;
          if (exp_q.size() == 0) begin
            mon_bad++;
            $display("FAIL %s/R9: actual request %0d expected none", cur_tag, idx);
          end else begin
            e = exp_q.pop_front();
            if (e != idx) begin
              mon_bad++;
              $display("FAIL %s: actual request %0d expected %0d", cur_tag, idx, e);
            end
          end
        end
        beats = 0;
      end
      if (idx >= 0) beats++;
      prev_idx = idx;
    end
  end

  task automatic run_job(int m, int op, int n, bit word, string tag);
    int d;
    int s0;
    int guard;
    d = op[0];
    @(negedge clk);
    cur_tag = tag;
    cfg_mode = m; cfg_dec = d;
    acc_word_i = word;
    mode_i = 2'(m); op_i = 2'(op);
    cm_en_i = 1'b1;
    if (m == 0) exp_q.push_back(1);
    for (int b = 0; b < n; b++) begin
      for (int s = 0; s < chain_len(m, d); s++) begin
        exp_q.push_back(s);
        if (port_for(m, d, s) == 0 && b == n - 1) break;
      end
    end
    s0 = starts_seen;
    blk_cnt_i = 8'(n);
    blk_wr_i = 1'b1;
    @(negedge clk);
    blk_wr_i = 1'b0;
    check(busy_o == 1'b1, "R2", busy_o, 1);
    if (m != 0) sw_req_total += (word ? 8 : 16);
    guard = 0;
    while (busy_o && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(busy_o == 1'b0 && trig_o == 3'b000, {tag, "/R11"}, {trig_o, busy_o}, 0);
    check(starts_seen - s0 == n, "R10", starts_seen - s0, n);
    check(exp_q.size() == 0, {tag, " order"}, exp_q.size(), 0);
    exp_q.delete();
    repeat (10) @(negedge clk);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             n_chk + mon_chk + wd_bad, n_bad + mon_bad + wd_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    wd_bad = 1;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(trig_o == 3'b000 && busy_o == 1'b0 && start_o == 1'b0, "R2 reset", {trig_o, busy_o, start_o}, 0);

    run_job(0, 0, 3, 1'b1, "R4");
    run_job(0, 1, 2, 1'b0, "R4");
    run_job(1, 0, 2, 1'b1, "R5");
    run_job(1, 3, 3, 1'b1, "R6");
    run_job(1, 1, 1, 1'b0, "R6");
    run_job(2, 0, 2, 1'b1, "R7");
    run_job(2, 1, 2, 1'b0, "R7");
    run_job(3, 0, 3, 1'b1, "R8");
    run_job(3, 1, 2, 1'b1, "R8");
    run_job(3, 3, 1, 1'b0, "R8");

    // R1: count write with enable low is ignored
    @(negedge clk);
    cm_en_i = 1'b0;
    mode_i = 2'b00;
    blk_cnt_i = 8'd3;
    blk_wr_i = 1'b1;
    @(negedge clk);
    blk_wr_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      check(busy_o == 1'b0 && trig_o == 3'b000, "R1 disabled", {trig_o, busy_o}, 0);
      @(negedge clk);
    end

    // R2: zero count leaves the block idle
    cm_en_i = 1'b1;
    blk_cnt_i = 8'd0;
    blk_wr_i = 1'b1;
    @(negedge clk);
    blk_wr_i = 1'b0;
    check(busy_o == 1'b0 && trig_o == 3'b000, "R2 zero count", {trig_o, busy_o}, 0);

    // R1: abort by dropping enable mid-chain
    mon_ignore = 1'b1;
    cfg_mode = 1; cfg_dec = 1;
    acc_word_i = 1'b1;
    mode_i = 2'b01; op_i = 2'b01;
    blk_cnt_i = 8'd3;
    blk_wr_i = 1'b1;
    @(negedge clk);
    blk_wr_i = 1'b0;
    sw_req_total += 8;
    for (int g = 0; g < 200 && trig_o == 3'b000; g++) @(negedge clk);
    check(trig_o != 3'b000, "R6 abort setup", trig_o, 1);
    repeat (2) @(negedge clk);
    cm_en_i = 1'b0;
    @(negedge clk);
    check(trig_o == 3'b000 && busy_o == 1'b0, "R1 abort", {trig_o, busy_o}, 0);
    repeat (12) @(negedge clk);
    check(trig_o == 3'b000 && busy_o == 1'b0 && start_o == 1'b0, "R1 stays idle", {trig_o, busy_o, start_o}, 0);
    mon_ignore = 1'b0;

    report();
    $finish;
  end

endmodule